// File: doc/BRIEF.md
# Two-Tier Single-Chip-Failure Line Codec

This block protects one cache line spread across a rank of nine memory chips. The 64-byte line is cut into eight 8-byte segments, one for each data chip. A ninth chip holds a parity segment, which is the bytewise XOR of the eight data segments. Each chip also stores a 16-bit checksum of its own segment. The checksum is the ones'-complement sum of the segment's four 16-bit words.

The write side is purely combinational. It builds the whole stored line (segments, checksums and parity) from the write data alone, so a write never needs the old contents. The read side is a two-stage pipeline with valid/ready handshakes on its input and its output.
- Stage one recomputes every checksum and compares it with the stored one. This is how the tier-one check detects and locates a bad chip.
- Stage two acts on the result. If exactly one chip disagrees, its segment is rebuilt from the other seven segments and the parity, which is the tier-two correction, and the corrected flag is raised.
- If two or more chips disagree, the line is passed through untouched and marked uncorrectable.

Top module: `lot_ecc_codec`

## Requirements
- R1: On the encode side, stored chip c (c = 0..7) occupies `enc_line[c*80 +: 80]`. Its bits [63:0] equal `enc_data[c*64 +: 64]`. Chip 8's bits [63:0] equal the XOR of the eight data segments.
- R2: For every chip, bits [79:64] of its 80-bit field hold the ones'-complement sum, with end-around carry, of the segment's 16-bit words. Word j is segment bits [16j+15:16j]. The result equals the plain sum taken modulo 65535, with a non-zero multiple of 65535 giving 16'hFFFF and a zero sum giving 16'h0000.
- R3: On decode, when no chip's checksum disagrees with its segment, `out_data` equals the 512 stored data bits. `out_corrected` and `out_uncorrectable` are both 0, and `out_fail_chip` is 0.
- R4: When exactly one data chip c disagrees, `out_data` holds the original data, with segment c rebuilt as the XOR of the other seven data segments and the parity segment. `out_corrected` is 1 and `out_fail_chip` equals c.
- R5: When only the parity chip disagrees, `out_data` equals the stored data segments. `out_corrected` is 1 and `out_fail_chip` equals 8.
- R6: When two or more chips disagree, `out_uncorrectable` is 1, `out_corrected` is 0 and `out_fail_chip` is 0. `out_data` equals the stored data segments without modification.
- R7: A line accepted on a clock edge (`in_valid` and `in_ready` both high) is presented with `out_valid` high after the second following edge, and not after the first.
- R8: While `out_valid` is high and `out_ready` is low, every decode output holds its value. Once both pipeline stages are full, `in_ready` is low and no line is lost.
- R9: After reset, `out_valid` is 0 and `in_ready` is 1.
- R10: `out_corrected` and `out_uncorrectable` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_data | input | 512 | Cache line to be written |
| enc_line | output | 720 | Nine 80-bit chip fields: segment and checksum |
| in_valid | input | 1 | Read line offered to decoder |
| in_ready | output | 1 | Decoder can take a line |
| in_line | input | 720 | Nine 80-bit chip fields as read back |
| out_valid | output | 1 | Decoded line available |
| out_ready | input | 1 | Consumer takes the decoded line |
| out_data | output | 512 | Decoded (possibly rebuilt) cache line |
| out_corrected | output | 1 | Exactly one chip was failed and handled |
| out_uncorrectable | output | 1 | Two or more chips failed |
| out_fail_chip | output | 4 | Index of the single failed chip, 0..8 |

## Verification
The bench builds the block with its default parameters: eight data chips, four 16-bit words per segment and one parity chip. This is small enough to cover the failure space exhaustively.
- Every one of the nine chips is corrupted on its own under three masks (a data bit, a whole word, and a checksum bit) across four data patterns.
- All 36 two-chip pairs are corrupted to reach the uncorrectable path.

The expected checksums and the expected mismatch sets come from a modulo-65535 model in the bench. A separate stall sequence fills both stages to exercise the hold behaviour.

// File: rtl/lot_ecc_codec.sv
module lot_ecc_codec #(
  parameter int N_DATA = 8,
  parameter int WORDS  = 4,
  parameter int WW     = 16
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic [N_DATA*WORDS*WW-1:0]                enc_data,
  output logic [(N_DATA+1)*(WORDS*WW+WW)-1:0]       enc_line,
  input  logic                                      in_valid,
  output logic                                      in_ready,
  input  logic [(N_DATA+1)*(WORDS*WW+WW)-1:0]       in_line,
  output logic                                      out_valid,
  input  logic                                      out_ready,
  output logic [N_DATA*WORDS*WW-1:0]                out_data,
  output logic                                      out_corrected,
  output logic                                      out_uncorrectable,
  output logic [$clog2(N_DATA+1)-1:0]               out_fail_chip
);
  localparam int SEG_W  = WORDS * WW;
  localparam int CHIP_W = SEG_W + WW;
  localparam int N_CHIP = N_DATA + 1;
  localparam int DATA_W = N_DATA * SEG_W;
  localparam int IDX_W  = $clog2(N_CHIP);

  function automatic logic [WW-1:0] ones_sum(input logic [SEG_W-1:0] seg);
    logic [2*WW-1:0] acc;
    acc = '0;
    for (int j = 0; j < WORDS; j++)
      acc = acc + {{WW{1'b0}}, seg[j*WW +: WW]};
    for (int k = 0; k < 2; k++)
      acc = {{WW{1'b0}}, acc[WW-1:0]} + {{WW{1'b0}}, acc[2*WW-1:WW]};
    return acc[WW-1:0];
  endfunction

  // encode
  logic [SEG_W-1:0] enc_par;
  always_comb begin
    enc_par = '0;
    for (int c = 0; c < N_DATA; c++) enc_par ^= enc_data[c*SEG_W +: SEG_W];
  end

  for (genvar c = 0; c < N_CHIP; c++) begin : g_enc
    logic [SEG_W-1:0] seg;
    if (c < N_DATA) begin : g_d
      assign seg = enc_data[c*SEG_W +: SEG_W];
    end else begin : g_p
      assign seg = enc_par;
    end
    assign enc_line[c*CHIP_W +: CHIP_W] = {ones_sum(seg), seg};
  end

  // stage 1: checksum compare
  logic [N_CHIP-1:0] mis_c;
  for (genvar c = 0; c < N_CHIP; c++) begin : g_chk
    assign mis_c[c] = ones_sum(in_line[c*CHIP_W +: SEG_W]) !=
                      in_line[c*CHIP_W + SEG_W +: WW];
  end

  logic                     s1_valid;
  logic [N_CHIP*CHIP_W-1:0] s1_line;
  logic [N_CHIP-1:0]        s1_mis;
  logic                     s2_adv;

  assign s2_adv   = s1_valid && (!out_valid || out_ready);
  assign in_ready = !s1_valid || s2_adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_line  <= '0;
      s1_mis   <= '0;
    end else if (in_ready) begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_line <= in_line;
        s1_mis  <= mis_c;
      end
    end
  end

  // stage 2: locate and rebuild
  logic [SEG_W-1:0]  all_xor;
  logic [IDX_W-1:0]  bad_idx;
  logic [DATA_W-1:0] fixed;
  logic              one_bad;
  logic              multi_bad;

  assign one_bad   = $countones(s1_mis) == 1;
  assign multi_bad = $countones(s1_mis) > 1;

  always_comb begin
    all_xor = '0;
    bad_idx = '0;
    for (int c = 0; c < N_CHIP; c++) begin
      all_xor ^= s1_line[c*CHIP_W +: SEG_W];
      if (s1_mis[c]) bad_idx = IDX_W'(c);
    end
    for (int c = 0; c < N_DATA; c++) begin
      fixed[c*SEG_W +: SEG_W] = s1_line[c*CHIP_W +: SEG_W];
      if (one_bad && s1_mis[c])
        fixed[c*SEG_W +: SEG_W] = s1_line[c*CHIP_W +: SEG_W] ^ all_xor;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid         <= 1'b0;
      out_data          <= '0;
      out_corrected     <= 1'b0;
      out_uncorrectable <= 1'b0;
      out_fail_chip     <= '0;
    end else if (!out_valid || out_ready) begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_data          <= fixed;
        out_corrected     <= one_bad;
        out_uncorrectable <= multi_bad;
        out_fail_chip     <= one_bad ? bad_idx : '0;
      end
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_corrected && out_uncorrectable)); // R10
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
    $stable(out_corrected) && $stable(out_uncorrectable) && $stable(out_fail_chip)); // R8
  AST_STAGE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> s1_valid); // R7
  AST_STAGE_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    s2_adv |=> out_valid); // R7
  AST_FAIL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_corrected |-> out_fail_chip < IDX_W'(N_CHIP)); // R4
  AST_UNC_IDX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_uncorrectable |-> out_fail_chip == '0); // R6
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid && out_valid && !out_ready |-> !in_ready); // R8
endmodule

// File: tb/tb_lot_ecc_codec.sv
module tb_lot_ecc_codec;
  localparam int CW = 80;
  localparam int LW = 720;
  localparam int DW = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] enc_data = '0;
  logic [LW-1:0] enc_line;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [LW-1:0] in_line = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic out_corrected, out_uncorrectable;
  logic [3:0] out_fail_chip;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lot_ecc_codec dut (
    .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_line(enc_line),
    .in_valid(in_valid), .in_ready(in_ready), .in_line(in_line),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_corrected(out_corrected), .out_uncorrectable(out_uncorrectable),
    .out_fail_chip(out_fail_chip));

  function automatic logic [15:0] model_sum(input logic [63:0] s);
    int unsigned t = 0;
    int unsigned r;
    for (int j = 0; j < 4; j++) t += s[j*16 +: 16];
    r = t % 65535;
    if (r == 0 && t != 0) r = 65535;
    return 16'(r);
  endfunction

  function automatic logic [LW-1:0] model_enc(input logic [DW-1:0] d);
    logic [LW-1:0] l;
    logic [63:0] p = '0;
    for (int c = 0; c < 8; c++) begin
      l[c*CW +: CW] = {model_sum(d[c*64 +: 64]), d[c*64 +: 64]};
      p ^= d[c*64 +: 64];
    end
    l[8*CW +: CW] = {model_sum(p), p};
    return l;
  endfunction

  function automatic logic [DW-1:0] make_data(input int seed);
    logic [DW-1:0] d;
    logic [31:0] x = 32'h1234_5678 + 32'(seed) * 32'h9E37_79B9;
    for (int k = 0; k < 16; k++) begin
      x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
      d[k*32 +: 32] = x;
    end
    return d;
  endfunction

  function automatic logic [CW-1:0] mask_of(input int m);
    case (m)
      0: return {16'h0000, 64'h0000_0000_0000_0001};
      1: return {16'h0000, 64'h0000_FFFF_0000_0000};
      default: return {16'h0100, 64'h0};
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic decode_one(input logic [DW-1:0] orig, input logic [LW-1:0] rd);
    logic [8:0] mis;
    int nm = 0;
    int bad = 0;
    logic [DW-1:0] exp_d;
    for (int c = 0; c < 9; c++) begin
      mis[c] = model_sum(rd[c*CW +: 64]) != rd[c*CW + 64 +: 16];
      if (mis[c]) begin nm++; bad = c; end
    end
    for (int c = 0; c < 8; c++) exp_d[c*64 +: 64] = rd[c*CW +: 64];
    if (nm == 1) exp_d = orig;
    @(negedge clk);
    in_line = rd; in_valid = 1'b1;
    check("R8 in_ready idle", DW'(in_ready), DW'(1));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 not after one edge", DW'(out_valid), DW'(0));
    @(posedge clk);
    @(negedge clk);
    check("R7 valid after two edges", DW'(out_valid), DW'(1));
    if (nm == 0) begin
      check("R3 data", out_data, exp_d);
      check("R3 flags", DW'({out_corrected, out_uncorrectable, out_fail_chip}), DW'(0));
    end else if (nm == 1 && bad < 8) begin
      check("R4 data", out_data, exp_d);
      check("R4 flags", DW'({out_corrected, out_uncorrectable, out_fail_chip}), DW'({2'b10, 4'(bad)}));
    end else if (nm == 1) begin
      check("R5 data", out_data, exp_d);
      check("R5 flags", DW'({out_corrected, out_uncorrectable, out_fail_chip}), DW'({2'b10, 4'd8}));
    end else begin
      check("R6 data", out_data, exp_d);
      check("R6 flags", DW'({out_corrected, out_uncorrectable, out_fail_chip}), DW'({2'b01, 4'd0}));
    end
    check("R10 exclusive", DW'(out_corrected & out_uncorrectable), DW'(0));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R9 out_valid", DW'(out_valid), DW'(0));
    check("R9 in_ready", DW'(in_ready), DW'(1));

    for (int p = 0; p < 4; p++) begin
      logic [DW-1:0] d = (p == 0) ? '0 : make_data(p);
      logic [LW-1:0] good = model_enc(d);
      logic [63:0] px = '0;
      enc_data = d;
      #1;
      for (int c = 0; c < 8; c++) begin
        check("R1 data segment", DW'(enc_line[c*CW +: 64]), DW'(d[c*64 +: 64]));
        px ^= d[c*64 +: 64];
      end
      check("R1 parity segment", DW'(enc_line[8*CW +: 64]), DW'(px));
      for (int c = 0; c < 9; c++)
        check("R2 checksum", DW'(enc_line[c*CW + 64 +: 16]), DW'(good[c*CW + 64 +: 16]));
      decode_one(d, good);
      for (int c = 0; c < 9; c++)
        for (int m = 0; m < 3; m++) begin
          logic [LW-1:0] bad = good;
          bad[c*CW +: CW] ^= mask_of(m);
          decode_one(d, bad);
        end
    end

    begin
      logic [DW-1:0] d = make_data(7);
      logic [LW-1:0] good = model_enc(d);
      for (int a = 0; a < 9; a++)
        for (int b = a + 1; b < 9; b++) begin
          logic [LW-1:0] bad = good;
          bad[a*CW +: CW] ^= mask_of(0);
          bad[b*CW +: CW] ^= mask_of(1);
          decode_one(d, bad);
        end
    end

    begin
      logic [DW-1:0] da = make_data(11);
      logic [DW-1:0] db = make_data(12);
      logic [LW-1:0] lb = model_enc(db);
      lb[3*CW +: CW] ^= mask_of(1);
      @(negedge clk);
      out_ready = 1'b0;
      in_line = model_enc(da); in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_line = lb;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 full blocks input", DW'(in_ready), DW'(0));
      for (int k = 0; k < 3; k++) begin
        check("R8 held valid", DW'(out_valid), DW'(1));
        check("R8 held data", out_data, da);
        @(negedge clk);
      end
      out_ready = 1'b1;
      @(negedge clk);
      check("R8 second line valid", DW'(out_valid), DW'(1));
      check("R8 second line rebuilt", out_data, db);
      check("R8 second line flags", DW'({out_corrected, out_fail_chip}), DW'({1'b1, 4'd3}));
      @(negedge clk);
      check("R8 drained", DW'(out_valid), DW'(0));
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule